// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

This block makes the bit clocks for a serial peripheral port. The transmit side and the receive side each have their own 16-bit scale setting. Both are derived from the parent clock. A setting is the product of two factors: a coarse prescale factor from 1 to 32, and a power-of-two factor from 2 to 32. One reserved code instead passes the parent clock straight through. For each side the block drives a serial clock waveform and two one-cycle strobes, one for each rising edge and one for each falling edge, which the shift logic uses.

A shared `run` input starts and stops both clocks. While `run` is low, each serial clock rests at the level given by `cpol`, and the counters stay cleared. The scale registers can be written at any time. A written value is copied into the active divider only while the clock is stopped, so the divisor never changes in the middle of a waveform.

Top module: `spi_sck_prescaler`

## Requirements
- R1: Two 16-bit scale registers exist, one for transmit and one for receive. `tx_scale_we` or `rx_scale_we` loads `scale_wdata` into its own register only. Both registers reset to 0, which selects a ratio of 2.
- R2: The divide ratio is P × Q. P is bits [12:8] plus 1, so 0x1F gives 32. Q is 2, 4, 8, 16 or 32 for bits [2:0] = 0, 1, 2, 3 or 4. The value 5 or 6 in bits [2:0] gives Q = 32. The serial clock toggles every ratio/2 parent cycles.
- R3: Bits [2:0] = 7 with bits [12:8] = 0 selects pass-through. While running, the serial clock equals the parent clock (inverted when `cpol` = 1), and both strobes stay high. Bits [2:0] = 7 with a non-zero [12:8] gives Q = 32.
- R4: Bits [15:13] and [7:3] of a scale value have no effect.
- R5: After reset, and on every cycle after an edge at which `run` was sampled low, each serial clock equals `cpol` and both strobes are low.
- R6: After `run` goes high, the first serial clock transition happens at the clock edge that is the ratio/2-th edge to sample `run` high. Later transitions follow every ratio/2 edges.
- R7: A rise strobe is high for exactly the one cycle in which the serial clock has just become 1. A fall strobe is high for the one cycle in which it has just become 0. Outside pass-through the two strobes are never high together.
- R8: A scale value written while running leaves the running waveform unchanged. The value becomes active at the first edge after the write that samples `run` low.
- R9: The two directions run at the same time with independent ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Starts (1) or stops (0) both serial clocks |
| cpol | input | 1 | Idle level of the serial clocks |
| tx_scale_we | input | 1 | Load strobe for the transmit scale register |
| rx_scale_we | input | 1 | Load strobe for the receive scale register |
| scale_wdata | input | 16 | Scale value to load |
| tx_sck | output | 1 | Transmit serial clock |
| tx_rise | output | 1 | Transmit clock rising-edge strobe |
| tx_fall | output | 1 | Transmit clock falling-edge strobe |
| rx_sck | output | 1 | Receive serial clock |
| rx_rise | output | 1 | Receive clock rising-edge strobe |
| rx_fall | output | 1 | Receive clock falling-edge strobe |

## Verification
The assertions assume that `cpol` is held steady while `run` is high. The edge-strobe properties compare the strobe with the clock level produced from `cpol`, so a change in the middle of a run would break them without any design fault. The stimulus changes `cpol` only during stopped intervals. It still writes scale values during running intervals, because those writes are the subject of R8. Every input is driven on the falling parent edge, which keeps each one stable across the rising edge that samples it.

// File: rtl/sckdiv_pkg.sv
// Shared field layout, configuration type and scale decoder for the
// serial clock prescaler. Assumes a 16-bit scale word.
package sckdiv_pkg;
    localparam int SCALE_W   = 16;
    localparam int PRE_LSB   = 8;
    localparam int PRE_W     = 5;
    localparam int POW_W     = 3;
    localparam int POW_K_MAX = 4;
    localparam int POW_CNT_W = POW_K_MAX;
    localparam logic [POW_W-1:0] CODE_BYPASS = 3'd7;

    typedef struct packed {
        logic             byp;     // pass parent clock through
        logic [PRE_W-1:0] pre_m1;  // prescale factor minus one
        logic [POW_W-1:0] pow_k;   // half-period power: 2^pow_k ticks
    } div_cfg_t;

    // Turn a raw scale word into the divider configuration.
    function automatic div_cfg_t decode_scale(input logic [SCALE_W-1:0] s);
        div_cfg_t c;
        logic [POW_W-1:0] lo;
        lo       = s[POW_W-1:0];
        c.pre_m1 = s[PRE_LSB +: PRE_W];
        c.byp    = (lo == CODE_BYPASS) && (c.pre_m1 == '0);
        c.pow_k  = (lo <= POW_W'(POW_K_MAX)) ? lo : POW_W'(POW_K_MAX);
        return c;
    endfunction
endpackage

// File: rtl/sck_scale_reg.sv
// One direction's scale register, plus the active configuration taken
// from it. Assumes the active copy may be refreshed whenever run is low.
module sck_scale_reg
    import sckdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               we,
    input  logic [SCALE_W-1:0] wdata,
    output div_cfg_t           cfg_o
);
    logic [SCALE_W-1:0] scale_q;
    div_cfg_t           cfg_q;

    // Hold the written scale word.
    always_ff @(posedge clk) begin
        if (!rst_n)  scale_q <= '0;
        else if (we) scale_q <= wdata;
    end

    // Copy the decoded word into the divider only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= decode_scale('0);
        else if (!run) cfg_q <= decode_scale(scale_q);
    end

    assign cfg_o = cfg_q;

    // R8: the active divisor is frozen while running
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(cfg_q));
endmodule

// File: rtl/sck_half_gen.sv
// Two-stage divider for one direction. The first stage prescales by
// (pre_m1+1). The second stage counts 2^pow_k prescaler ticks for each
// half period, then toggles the clock phase. Assumes cpol is steady while
// run is high. The counters clear while run is low.
module sck_half_gen
    import sckdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     cpol,
    input  div_cfg_t cfg_i,
    output logic     sck_o,
    output logic     rise_o,
    output logic     fall_o
);
    logic [PRE_W-1:0]     pre_cnt;
    logic [POW_CNT_W-1:0] pow_cnt;
    logic [POW_CNT_W-1:0] pow_lim;
    logic                 tick, wrap;
    logic                 ph, run_r, rise_q, fall_q;

    // Terminal counts for the two stages.
    always_comb begin
        pow_lim = POW_CNT_W'((32'd1 << cfg_i.pow_k) - 32'd1);
        tick    = (pre_cnt == cfg_i.pre_m1);
        wrap    = tick && (pow_cnt == pow_lim);
    end

    // Counters, phase and edge strobes, all cleared when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            pow_cnt <= '0;
            ph      <= 1'b0;
            run_r   <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            run_r <= 1'b1;
            if (cfg_i.byp) begin
                rise_q <= 1'b1;
                fall_q <= 1'b1;
            end else begin
                pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
                if (tick) pow_cnt <= wrap ? '0 : pow_cnt + 1'b1;
                if (wrap) ph <= ~ph;
                rise_q <= wrap && (ph == cpol);
                fall_q <= wrap && (ph != cpol);
            end
        end
    end

    // Output level: idle, pass-through, or divided phase.
    always_comb begin
        if (!run_r)         sck_o = cpol;
        else if (cfg_i.byp) sck_o = clk ^ cpol;
        else                sck_o = ph ^ cpol;
    end

    assign rise_o = rise_q;
    assign fall_o = fall_q;

    // R5: stopping clears the strobes and the run state
    a_r5_quiet_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!rise_q && !fall_q && !run_r));
    // R7: a rise strobe comes with a high divided clock
    a_r7_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q && !cfg_i.byp) |-> (ph ^ cpol));
    // R7: the two strobes never coincide outside pass-through
    a_r7_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.byp |-> !(rise_q && fall_q));
    // R2: the power-of-two stage stays within its half-period count
    a_r2_pow_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run_r && !cfg_i.byp) |-> (pow_cnt <= pow_lim));
    // R3: pass-through keeps both strobes high while running
    a_r3_bypass_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.byp && run_r) |-> (rise_q && fall_q));
endmodule

// File: rtl/spi_sck_prescaler.sv
// Top level: one scale register and one two-stage divider for each
// direction (index 0 transmit, 1 receive), with shared run and polarity.
module spi_sck_prescaler
    import sckdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               cpol,
    input  logic               tx_scale_we,
    input  logic               rx_scale_we,
    input  logic [SCALE_W-1:0] scale_wdata,
    output logic               tx_sck,
    output logic               tx_rise,
    output logic               tx_fall,
    output logic               rx_sck,
    output logic               rx_rise,
    output logic               rx_fall
);
    localparam int NUM_DIR = 2;

    logic [NUM_DIR-1:0] we_v, sck_v, rise_v, fall_v;
    div_cfg_t           cfg_v [NUM_DIR];

    assign we_v = {rx_scale_we, tx_scale_we};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        sck_scale_reg u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .we    (we_v[d]),
            .wdata (scale_wdata),
            .cfg_o (cfg_v[d])
        );
        sck_half_gen u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .cpol   (cpol),
            .cfg_i  (cfg_v[d]),
            .sck_o  (sck_v[d]),
            .rise_o (rise_v[d]),
            .fall_o (fall_v[d])
        );
    end

    assign tx_sck  = sck_v[0];
    assign tx_rise = rise_v[0];
    assign tx_fall = fall_v[0];
    assign rx_sck  = sck_v[1];
    assign rx_rise = rise_v[1];
    assign rx_fall = fall_v[1];
endmodule

// File: tb/spi_sck_prescaler_tb_top.sv
// Behavioural reference model compared with the design on every falling edge.
module spi_sck_prescaler_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic cpol = 1'b0;
    logic tx_scale_we = 1'b0;
    logic rx_scale_we = 1'b0;
    logic [15:0] scale_wdata = '0;
    logic tx_sck, tx_rise, tx_fall, rx_sck, rx_rise, rx_fall;

    int vectors = 0;
    int errors = 0;
    string req = "R5";

    int m_reg [2];
    int m_ratio [2];
    int m_cyc [2];
    bit m_rr [2];
    bit m_ph [2];
    bit m_r [2];
    bit m_f [2];

    always #2 clk = ~clk;

    spi_sck_prescaler dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol),
        .tx_scale_we(tx_scale_we), .rx_scale_we(rx_scale_we),
        .scale_wdata(scale_wdata),
        .tx_sck(tx_sck), .tx_rise(tx_rise), .tx_fall(tx_fall),
        .rx_sck(rx_sck), .rx_rise(rx_rise), .rx_fall(rx_fall)
    );

    // Ratio from the field rules (R2, R3, R4); 1 means pass-through.
    function automatic int ratio_of(input int s);
        int lo = s & 7;
        int pf = (s >> 8) & 31;
        int pw;
        if (lo == 7 && pf == 0) return 1;
        pw = (lo <= 4) ? (2 << lo) : 32;
        return (pf + 1) * pw;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            bit we_d;
            we_d = (d == 0) ? tx_scale_we : rx_scale_we;
            if (!rst_n) begin
                m_reg[d] = 0; m_ratio[d] = 2; m_cyc[d] = 0;
                m_rr[d] = 0; m_ph[d] = 0; m_r[d] = 0; m_f[d] = 0;
            end else begin
                if (!run) begin
                    m_ratio[d] = ratio_of(m_reg[d]);
                    m_rr[d] = 0; m_cyc[d] = 0; m_ph[d] = 0; m_r[d] = 0; m_f[d] = 0;
                end else begin
                    m_rr[d] = 1;
                    if (m_ratio[d] == 1) begin
                        m_r[d] = 1; m_f[d] = 1;
                    end else begin
                        m_r[d] = 0; m_f[d] = 0;
                        m_cyc[d]++;
                        if (m_cyc[d] == m_ratio[d] / 2) begin
                            m_cyc[d] = 0;
                            m_ph[d] = ~m_ph[d];
                            if ((m_ph[d] ^ cpol) == 1'b1) m_r[d] = 1;
                            else m_f[d] = 1;
                        end
                    end
                end
                if (we_d) m_reg[d] = int'(scale_wdata);
            end
        end
    end

    // Compare one direction's outputs with the model (clk low here).
    task automatic compare_dir(input int d, input bit s, input bit r, input bit f);
        bit es;
        es = m_rr[d] ? ((m_ratio[d] == 1) ? cpol : (m_ph[d] ^ cpol)) : cpol;
        vectors++;
        if ({s, r, f} !== {es, m_r[d], m_f[d]}) begin
            errors++;
            $display("FAIL %s dir%0d sck/rise/fall got %b%b%b expected %b%b%b at %0t",
                     req, d, s, r, f, es, m_r[d], m_f[d], $time);
        end
    endtask

    // Advance n cycles, checking both directions on each falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_dir(0, tx_sck, tx_rise, tx_fall);
            compare_dir(1, rx_sck, rx_rise, rx_fall);
        end
    endtask

    // Stop, load both scale registers, then run for n cycles.
    task automatic config_run(input logic [15:0] tx_v, input logic [15:0] rx_v,
                              input bit pol, input int n);
        run = 1'b0;
        step(1);
        cpol = pol;
        tx_scale_we = 1'b1; scale_wdata = tx_v;
        step(1);
        tx_scale_we = 1'b0; rx_scale_we = 1'b1; scale_wdata = rx_v;
        step(1);
        rx_scale_we = 1'b0;
        step(2);
        run = 1'b1;
        step(n);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired in phase %s", req);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R5: reset state, then idle at both polarities
        step(3);
        rst_n = 1'b1;
        step(3);
        cpol = 1'b1;
        step(2);
        // R1 and R6: default ratio 2 from reset on transmit
        req = "R1";
        run = 1'b1;
        step(12);
        // R9 and R2: tx ratio 2, rx ratio 16 together
        req = "R9";
        config_run(16'h0000, 16'h0003, 1'b0, 80);
        // R2: largest ratio 1024; rx prescale 6 x 4 = 24
        req = "R2";
        config_run(16'h1F04, 16'h0501, 1'b0, 2200);
        // R2: codes 5 and 6 act as 32; cpol = 1 (R7 strobes)
        req = "R7";
        config_run(16'h0005, 16'h0206, 1'b1, 400);
        // R4: ignored bits set; R3: code 7 with prescale 4 gives 128
        req = "R4";
        config_run(16'hE0F9, 16'h0307, 1'b0, 300);
        // R3: pass-through at both polarities, also sampled with clk high
        req = "R3";
        for (int p = 0; p < 2; p++) begin
            config_run(16'h0007, 16'h0001, p[0], 10);
            for (int i = 0; i < 4; i++) begin
                @(posedge clk);
                #1;
                vectors++;
                if (tx_sck !== ~cpol) begin
                    errors++;
                    $display("FAIL R3 pass-through high phase got %b expected %b", tx_sck, ~cpol);
                end
            end
            step(2);
        end
        // R8: a write while running waits for the next stop
        req = "R8";
        config_run(16'h0001, 16'h0002, 1'b0, 20);
        tx_scale_we = 1'b1; scale_wdata = 16'h0003;
        step(1);
        tx_scale_we = 1'b0;
        step(60);
        run = 1'b0;
        step(3);
        run = 1'b1;
        step(80);
        // R6: short stop and restart restarts the half-period count
        req = "R6";
        config_run(16'h0102, 16'h1F00, 1'b1, 150);
        run = 1'b0;
        step(1);
        run = 1'b1;
        step(100);
        run = 1'b0;
        step(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule